// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block steers each bit time of a serial time-division-multiplexed frame to one of several logical serial channels. Two routing tables, one for receive and one for transmit, each list runs of bits or bytes. Every run names a destination channel. The assigner walks its table from the first entry when a frame sync arrives. For every bit time it raises at most one enable toward the serial controllers, or none while a run is skipped. It can also raise a separate grant strobe. The serial clock is the block clock, so one clock cycle is one bit time.

A host loads the tables through a simple write port while the assigner is disabled. On the receive side, a bit marked with the grant code is captured from the receive data line and held as the grant input for the channel that carries signalling. The two directions walk on their own, each from its own frame sync.

Top module: `tdm_slot_router`

## Requirements
- R1: A routing entry is 16 bits: bits [2:0] hold the channel code, bits [6:3] the count, bit 7 the unit flag (1 = bytes), bit 8 the last-entry flag. Channel code 001 drives slot enable bit 0, 010 drives bit 1, 100 drives bit 2, 101 (management) drives bit 3, 000 skips the run, and 111 drives the grant strobe.
- R2: The count holds the run length minus one. In bit units a run lasts count+1 bit times. In byte units it lasts 8×(count+1) bit times, which is 128 at the largest count.
- R3: Entries are walked in increasing address order. When the run of an entry with the last flag set ends, no enable or grant strobe is asserted until the next frame sync.
- R4: A frame sync sampled with the assigner enabled restarts the walk at entry 0 from any point, including the middle of a frame. The first bit time of the frame is the clock cycle after the sync edge.
- R5: Per direction, at most one of the four slot enables and the grant strobe is asserted in any cycle.
- R6: At the end of a receive bit time with the grant strobe asserted, rx_dat is captured into rx_grant. rx_grant keeps its value at all other times.
- R7: A cfg_addr with bit 7 clear writes receive entry cfg_addr[5:0]. A cfg_addr with bit 7 set writes transmit entry cfg_addr[5:0], so the transmit table starts at address 128. A write with cfg_addr bit 6 set is ignored.
- R8: Table writes made while en is high are ignored.
- R9: Reset fills every entry with 16'h0100, which sets only the last flag, clears rx_grant and idles all strobes. While en is low, all strobes are low from the next cycle and frame syncs are ignored.
- R10: Entry 63 ends the walk even when its last flag is clear.
- R11: The reserved channel codes 011 and 110 behave as skips: they raise no strobe for the length of their run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Assigner enable; table writes are blocked while high |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table write address (bit 7 selects the transmit table) |
| cfg_wdata | input | 16 | Routing entry to write |
| rx_sync | input | 1 | Receive frame sync pulse |
| tx_sync | input | 1 | Transmit frame sync pulse |
| rx_dat | input | 1 | Receive serial data, sampled for the grant bit |
| rx_slot_en | output | 4 | Receive enables {management, ch4, ch2, ch1} |
| rx_grant_strobe | output | 1 | Receive grant-sampling strobe |
| tx_slot_en | output | 4 | Transmit enables {management, ch4, ch2, ch1} |
| tx_grant_strobe | output | 1 | Transmit grant-code strobe |
| rx_grant | output | 1 | Captured grant bit |

## Verification
The hardest case to reach from the ports is the end of a long walk: entry 63 has no last flag, and the largest byte run sits well past 100 bit times. Both can only be seen after a full table load and a long frame. The bench fills all 64 receive entries with one-bit runs that carry no last flag. It then loads a table that starts with reserved-code skips and ends with a 128-bit byte run. After each load it follows the strobes bit by bit, through the last active bit and the first idle bit. The grant capture is checked with rx_dat driven both ways around the grant slot, so a capture taken one bit early or late shows up as a wrong value.

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter int ENTRIES = 64,
  parameter int ENTRY_W = 16,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic               rx_sync,
  input  logic               tx_sync,
  input  logic               rx_dat,
  output logic [3:0]         rx_slot_en,
  output logic               rx_grant_strobe,
  output logic [3:0]         tx_slot_en,
  output logic               tx_grant_strobe,
  output logic               rx_grant
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int RUN_W  = CNT_W + 3;
  localparam int UNIT_B = 3 + CNT_W;
  localparam int LAST_B = 4 + CNT_W;
  localparam logic [ENTRY_W-1:0] FILL = ENTRY_W'(1) << LAST_B;

  function automatic logic [RUN_W-1:0] run_len(input logic [ENTRY_W-1:0] e);
    logic [CNT_W-1:0] c;
    c = e[3 +: CNT_W];
    return e[UNIT_B] ? {c, 3'b111} : {3'b000, c};
  endfunction

  logic [1:0] sync_v;
  logic [3:0] slot_v [2];
  logic [1:0] grant_v;

  assign sync_v          = {tx_sync, rx_sync};
  assign rx_slot_en      = slot_v[0];
  assign tx_slot_en      = slot_v[1];
  assign rx_grant_strobe = grant_v[0];
  assign tx_grant_strobe = grant_v[1];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [ENTRY_W-1:0] tbl [ENTRIES];
    logic [IDX_W-1:0]   ptr;
    logic [RUN_W-1:0]   rem;
    logic               run;
    logic [ENTRY_W-1:0] cur, nxt;
    logic [2:0]         code;
    logic               wr;

    assign cur  = tbl[ptr];
    assign nxt  = tbl[ptr + 1'b1];
    assign code = cur[2:0];
    assign wr   = cfg_we && !en && (cfg_addr[ADDR_W-1] == 1'(d))
                  && (cfg_addr[ADDR_W-2:IDX_W] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++) tbl[i] <= FILL;
        ptr <= '0;
        rem <= '0;
        run <= 1'b0;
      end else begin
        if (wr) tbl[cfg_addr[IDX_W-1:0]] <= cfg_wdata;
        if (!en) begin
          run <= 1'b0;
        end else if (sync_v[d]) begin
          ptr <= '0;
          rem <= run_len(tbl[0]);
          run <= 1'b1;
        end else if (run) begin
          if (rem != '0) begin
            rem <= rem - 1'b1;
          end else if (cur[LAST_B] || ptr == IDX_W'(ENTRIES - 1)) begin
            run <= 1'b0;
          end else begin
            ptr <= ptr + 1'b1;
            rem <= run_len(nxt);
          end
        end
      end
    end

    assign slot_v[d][0] = run && code == 3'b001;
    assign slot_v[d][1] = run && code == 3'b010;
    assign slot_v[d][2] = run && code == 3'b100;
    assign slot_v[d][3] = run && code == 3'b101;
    assign grant_v[d]   = run && code == 3'b111;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_grant <= 1'b0;
    else if (grant_v[0]) rx_grant <= rx_dat;
  end
endmodule

module tdm_slot_router_chk #(
  parameter int ENTRY_W = 16,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [ENTRY_W-1:0] cfg_wdata,
  input logic               rx_sync,
  input logic               tx_sync,
  input logic               rx_dat,
  input logic [3:0]         rx_slot_en,
  input logic               rx_grant_strobe,
  input logic [3:0]         tx_slot_en,
  input logic               tx_grant_strobe,
  input logic               rx_grant
);
  assert_rx_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_grant_strobe, rx_slot_en}));
  assert_tx_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_grant_strobe, tx_slot_en}));
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_slot_en == 4'b0 && !rx_grant_strobe && tx_slot_en == 4'b0 && !tx_grant_strobe));
  assert_grant_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant_strobe |=> rx_grant == $past(rx_dat));
  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_grant_strobe |=> $stable(rx_grant));
endmodule

bind tdm_slot_router tdm_slot_router_chk u_chk (.*);

// File: tb/tdm_slot_router_bench.sv
`timescale 1ns/1ps
module tdm_slot_router_bench;
  logic clk = 0, rst_n = 0, en = 0, cfg_we = 0, rx_sync = 0, tx_sync = 0, rx_dat = 0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  rx_slot_en, tx_slot_en;
  logic        rx_grant_strobe, tx_grant_strobe, rx_grant;

  tdm_slot_router u_tdm_slot_router (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [4:0] exp_rx [200];
  logic [4:0] exp_tx [200];

  // example frame: {start, length, expected {grant,mgmt,ch4,ch2,ch1}}
  localparam logic [23:0] SEG [8] = '{
    {8'd0, 8'd8, 8'h02}, {8'd8, 8'd8, 8'h04}, {8'd16, 8'd8, 8'h08},
    {8'd24, 8'd2, 8'h01}, {8'd26, 8'd6, 8'h08}, {8'd32, 8'd56, 8'h00},
    {8'd88, 8'd2, 8'h00}, {8'd90, 8'd1, 8'h10}};
  localparam logic [15:0] EX_TBL [8] = '{
    16'h0082, 16'h0084, 16'h0085, 16'h0009, 16'h002D, 16'h00B0, 16'h0008, 16'h0107};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 200; i++) begin exp_rx[i] = '0; exp_tx[i] = '0; end
  endtask

  task automatic fill_rx(input int s, input int n, input logic [4:0] v);
    for (int i = s; i < s + n; i++) exp_rx[i] = v;
  endtask

  task automatic pulse_sync();
    rx_sync = 1; tx_sync = 1;
    @(negedge clk);
    rx_sync = 0; tx_sync = 0;
  endtask

  // runs nbits bit times after a sync; grant slot gets gv, other bits ~gv
  task automatic run_frame(input string req, input int nbits, input int gslot, input logic gv,
                           input logic gprev);
    pulse_sync();
    for (int t = 0; t < nbits; t++) begin
      chk(req, {rx_grant_strobe, rx_slot_en}, exp_rx[t]);
      chk(req, {tx_grant_strobe, tx_slot_en}, exp_tx[t]);
      if (gslot >= 0 && t == gslot)     chk("R6 hold", rx_grant, gprev);
      if (gslot >= 0 && t == gslot + 1) chk("R6 capture", rx_grant, gv);
      rx_dat = (t == gslot) ? gv : ~gv;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset rx", {rx_grant_strobe, rx_slot_en}, 0);
    chk("R9 reset tx", {tx_grant_strobe, tx_slot_en}, 0);
    chk("R9 reset grant", rx_grant, 0);
    rst_n = 1;
    @(negedge clk);

    // reset-filled tables end immediately after one skipped bit
    en = 1;
    clear_exp();
    run_frame("R9 fill", 3, -1, 0, 0);

    // load example rx frame and a short tx frame
    en = 0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) wr(8'(i), EX_TBL[i]);
    wr(8'd128, 16'h0081);
    wr(8'd129, 16'h0114);
    wr(8'h40, 16'h0101);  // R7: bit 6 set, must be ignored
    en = 1;
    clear_exp();
    for (int s = 0; s < 8; s++) fill_rx(int'(SEG[s][23:16]), int'(SEG[s][15:8]), SEG[s][4:0]);
    for (int i = 0; i < 8; i++) exp_tx[i] = 5'h01;
    for (int i = 8; i < 11; i++) exp_tx[i] = 5'h04;
    run_frame("R1/R2/R3/R7 frame", 96, 90, 1'b1, 1'b0);

    // R8: write while enabled is ignored
    wr(8'd0, 16'h0101);
    run_frame("R8 frame", 96, 90, 1'b0, 1'b1);

    // R4: mid-frame sync restarts at entry 0
    pulse_sync();
    repeat (19) @(negedge clk);
    chk("R4 pre", {rx_grant_strobe, rx_slot_en}, 5'h08);
    run_frame("R4 restart", 12, -1, 0, 0);

    // R9: disable idles strobes, sync ignored while off
    pulse_sync();
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R9 off rx", {rx_grant_strobe, rx_slot_en}, 0);
    chk("R9 off tx", {tx_grant_strobe, tx_slot_en}, 0);
    pulse_sync();
    chk("R9 sync off", {rx_grant_strobe, rx_slot_en}, 0);

    // R10: 64 one-bit ch1 entries with no last flag
    for (int i = 0; i < 64; i++) wr(8'(i), 16'h0001);
    en = 1;
    clear_exp();
    fill_rx(0, 64, 5'h01);
    for (int i = 0; i < 8; i++) exp_tx[i] = 5'h01;
    for (int i = 8; i < 11; i++) exp_tx[i] = 5'h04;
    run_frame("R10 walk", 67, -1, 0, 0);

    // R11 reserved codes skip, R2 largest byte run
    en = 0;
    @(negedge clk);
    wr(8'd0, 16'h0013);
    wr(8'd1, 16'h0006);
    wr(8'd2, 16'h01FC);
    en = 1;
    clear_exp();
    fill_rx(4, 128, 5'h04);
    for (int i = 0; i < 8; i++) exp_tx[i] = 5'h01;
    for (int i = 8; i < 11; i++) exp_tx[i] = 5'h04;
    run_frame("R11/R2 max run", 134, -1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule